// File: doc/BRIEF.md
# Three-Register Evaluation Stack

This block holds the operand stack of a small stack-oriented datapath: three registers of `WIDTH` bits, with the top register presenting the next operand. Each clock cycle it accepts one command. The commands are:

- push a value;
- pop;
- one of four reorderings;
- write back a result that an external arithmetic unit computed from the top two entries;
- a conditional-jump test on the top entry.

The block does no arithmetic itself. For a push or a result write-back, the surrounding logic supplies the value on the data input.

A pop does not discard the departing top value. That value moves into the bottom register, so pop behaves as a rotation. The conditional-jump test reports "taken" combinationally in the same cycle when the top entry is zero, and then leaves the stack alone. A nonzero top entry reports "not taken" and pops the stack.

Top module: `eval_stack`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, outputs `top_o`, `mid_o` and `bot_o` all read zero.
- R2: Command code 0 (idle) and every code from 9 to 15 leave all three registers unchanged and hold `jump_taken_o` low.
- R3: Code 1 (push) gives top = data input, mid = old top, bot = old mid.
- R4: Code 2 (pop) gives top = old mid, mid = old bot, bot = old top.
- R5: Code 3 (rotate) turns (top, mid, bot) = (a, b, c) into (b, c, a).
- R6: Code 4 (anti-rotate) turns (a, b, c) into (c, a, b).
- R7: Code 5 (swap) turns (a, b, c) into (b, a, c).
- R8: Code 6 (duplicate) turns (a, b, c) into (a, a, b).
- R9: Code 7 (result write-back) gives top = data input, mid = old bot, bot = old top.
- R10: Code 8 (conditional jump) with a zero top drives `jump_taken_o` high in the same cycle and leaves all three registers unchanged.
- R11: Code 8 with a nonzero top drives `jump_taken_o` low and applies the same change as a pop.
- R12: `jump_taken_o` is low in any cycle whose command is not code 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code for this cycle |
| data_i | input | WIDTH | Value for push or result write-back |
| top_o | output | WIDTH | Top of stack |
| mid_o | output | WIDTH | Middle entry |
| bot_o | output | WIDTH | Bottom entry |
| jump_taken_o | output | 1 | Conditional jump taken (combinational) |

## Verification
The assertions assume that `cmd_i` and `data_i` are stable around each rising edge and never unknown once reset is released. They also take the value on `data_i` as meaningful only in push and write-back cycles. The stimulus changes inputs only at falling edges. It applies every one of the sixteen command codes to several register patterns, and for each code it runs once with a zero top entry and once with a nonzero top entry. This covers both branches of the jump test and confirms that the unused codes have no effect.

// File: rtl/evstk_pkg.sv
package evstk_pkg;

    localparam int CMD_W  = 4;
    localparam int SLOTS  = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [CMD_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_ROT   = 4'd3,
        OP_AROT  = 4'd4,
        OP_SWAP  = 4'd5,
        OP_DUP   = 4'd6,
        OP_WBACK = 4'd7,
        OP_CJUMP = 4'd8
    } evstk_op_e;

    // Source of the next value of a stack slot.
    typedef enum logic [SEL_W-1:0] {
        SRC_TOP = 2'd0,
        SRC_MID = 2'd1,
        SRC_BOT = 2'd2,
        SRC_IN  = 2'd3
    } evstk_src_e;

    // Slot 0 = top, 1 = mid, 2 = bot.
    typedef struct packed {
        logic [SLOTS-1:0][SEL_W-1:0] sel;
    } evstk_route_t;

endpackage

// File: rtl/evstk_decode.sv
module evstk_decode
    import evstk_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             top_zero_i,
    output evstk_route_t     route_o,
    output logic             jump_taken_o
);

    function automatic evstk_route_t mk(evstk_src_e t, evstk_src_e m, evstk_src_e b);
        evstk_route_t r;
        r.sel[0] = t;
        r.sel[1] = m;
        r.sel[2] = b;
        return r;
    endfunction

    always_comb begin
        route_o      = mk(SRC_TOP, SRC_MID, SRC_BOT);
        jump_taken_o = 1'b0;
        case (cmd_i)
            OP_PUSH:  route_o = mk(SRC_IN,  SRC_TOP, SRC_MID);
            OP_POP,
            OP_ROT:   route_o = mk(SRC_MID, SRC_BOT, SRC_TOP);
            OP_AROT:  route_o = mk(SRC_BOT, SRC_TOP, SRC_MID);
            OP_SWAP:  route_o = mk(SRC_MID, SRC_TOP, SRC_BOT);
            OP_DUP:   route_o = mk(SRC_TOP, SRC_TOP, SRC_MID);
            OP_WBACK: route_o = mk(SRC_IN,  SRC_BOT, SRC_TOP);
            OP_CJUMP: begin
                if (top_zero_i) begin
                    jump_taken_o = 1'b1;
                end else begin
                    route_o = mk(SRC_MID, SRC_BOT, SRC_TOP);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/evstk_regs.sv
module evstk_regs
    import evstk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evstk_route_t     route_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] mid_o,
    output logic [WIDTH-1:0] bot_o
);

    typedef struct packed {
        logic [WIDTH-1:0] top;
        logic [WIDTH-1:0] mid;
        logic [WIDTH-1:0] bot;
    } state_t;

    state_t st_d, st_q;
    logic [WIDTH-1:0] pick_d [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            case (evstk_src_e'(route_i.sel[g]))
                SRC_TOP: pick_d[g] = st_q.top;
                SRC_MID: pick_d[g] = st_q.mid;
                SRC_BOT: pick_d[g] = st_q.bot;
                default: pick_d[g] = data_i;
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.top = pick_d[0];
        st_d.mid = pick_d[1];
        st_d.bot = pick_d[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_o = st_q.top;
    assign mid_o = st_q.mid;
    assign bot_o = st_q.bot;

endmodule

// File: rtl/eval_stack.sv
module eval_stack
    import evstk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cmd_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] mid_o,
    output logic [WIDTH-1:0] bot_o,
    output logic             jump_taken_o
);

    evstk_route_t route;
    logic         top_zero;

    assign top_zero = (top_o == '0);

    evstk_decode u_decode (
        .cmd_i        (cmd_i),
        .top_zero_i   (top_zero),
        .route_o      (route),
        .jump_taken_o (jump_taken_o)
    );

    evstk_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .route_i (route),
        .data_i  (data_i),
        .top_o   (top_o),
        .mid_o   (mid_o),
        .bot_o   (bot_o)
    );

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (top_o == '0 && mid_o == '0 && bot_o == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd0 || cmd_i > 4'd8) |=> ($stable(top_o) && $stable(mid_o) && $stable(bot_o)));

    p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd1 |=> (top_o == $past(data_i) && mid_o == $past(top_o) && bot_o == $past(mid_o)));

    p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd2 |=> (top_o == $past(mid_o) && mid_o == $past(bot_o) && bot_o == $past(top_o)));

    p_rot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd3 |=> (top_o == $past(mid_o) && mid_o == $past(bot_o) && bot_o == $past(top_o)));

    p_arot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd4 |=> (top_o == $past(bot_o) && mid_o == $past(top_o) && bot_o == $past(mid_o)));

    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd5 |=> (top_o == $past(mid_o) && mid_o == $past(top_o) && bot_o == $past(bot_o)));

    p_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd6 |=> (top_o == $past(top_o) && mid_o == $past(top_o) && bot_o == $past(mid_o)));

    p_wback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 4'd7 |=> (top_o == $past(data_i) && mid_o == $past(bot_o) && bot_o == $past(top_o)));

    p_cj_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd8 && top_o == '0) |-> jump_taken_o ##1
        ($stable(top_o) && $stable(mid_o) && $stable(bot_o)));

    p_cj_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd8 && top_o != '0) |-> !jump_taken_o ##1
        (top_o == $past(mid_o) && mid_o == $past(bot_o) && bot_o == $past(top_o)));

    p_flag_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i != 4'd8 |-> !jump_taken_o);

endmodule

// File: tb/eval_stack_tb_top.sv
module eval_stack_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cmd = 4'd0;
    logic [W-1:0] din = '0;
    logic [W-1:0] top, mid, bot;
    logic         jt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] ea, eb, ec;

    always #4 clk = ~clk;

    eval_stack #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .data_i(din),
        .top_o(top), .mid_o(mid), .bot_o(bot), .jump_taken_o(jt)
    );

    function automatic string req_of(int c, bit zero_top);
        case (c)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            8: return zero_top ? "R10" : "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(int c, logic [W-1:0] v);
        logic [W-1:0] a0, b0, c0;
        logic exp_jt;
        string r;
        a0 = ea; b0 = eb; c0 = ec;
        r = req_of(c, ea == '0);
        cmd = c[3:0];
        din = v;
        exp_jt = 1'b0;
        case (c)
            1: begin ea = v;  eb = a0; ec = b0; end
            2, 3: begin ea = b0; eb = c0; ec = a0; end
            4: begin ea = c0; eb = a0; ec = b0; end
            5: begin ea = b0; eb = a0; ec = c0; end
            6: begin ea = a0; eb = a0; ec = b0; end
            7: begin ea = v;  eb = c0; ec = a0; end
            8: begin
                if (a0 == '0) exp_jt = 1'b1;
                else begin ea = b0; eb = c0; ec = a0; end
            end
            default: ;
        endcase
        #1;
        chk((c == 8) ? r : "R12", "jump flag", {{(W-1){1'b0}}, jt}, {{(W-1){1'b0}}, exp_jt});
        @(posedge clk);
        @(negedge clk);
        chk(r, "top", top, ea);
        chk(r, "mid", mid, eb);
        chk(r, "bot", bot, ec);
    endtask

    initial begin
        logic [W-1:0] pat;
        repeat (3) @(negedge clk);
        chk("R1", "top in reset", top, '0);
        chk("R1", "mid in reset", mid, '0);
        chk("R1", "bot in reset", bot, '0);
        rst_n = 1'b1;
        ea = '0; eb = '0; ec = '0;
        @(negedge clk);
        chk("R1", "top after reset", top, '0);
        chk("R1", "mid after reset", mid, '0);
        chk("R1", "bot after reset", bot, '0);
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int z = 0; z < 2; z++) begin
                    pat = 32'h1357_9BDF * (p + 1) + 32'h0101 * c;
                    step(1, pat ^ 32'hA5A5_0000);
                    step(1, pat + 32'd7);
                    step(1, (z == 1) ? '0 : (pat | 32'd1));
                    step(c, ~pat);
                end
            end
        end
        // Jump test on a stack holding all zeros: taken, stays zero.
        step(1, '0); step(1, '0); step(1, '0);
        step(8, 32'hFFFF_FFFF);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule